// File: doc/BRIEF.md
# Interrupt Flag and Mask Controller

This block gathers seven peripheral interrupt causes into one request line for a processor. Each cause has a sticky flag bit, raised by a one-cycle pulse from the logic that detects the event. Other blocks can lower a flag with their own clear pulses. Software can also lower flags by writing ones to the flag register. A separate mask register chooses which flags may drive the request.

The mask register is written in a set/clear style. The top bit of the written byte chooses whether the ones in the low seven bits turn mask bits on or off. Bits written as zero keep their value.

Reading the flag register returns the seven stored flags. Bit 7 is not stored: it shows the live request, meaning whether any flag is pending while its mask bit is on. The request pin is active-low and registered. It follows the live request one clock later.

Top module: `irq_mask_unit`

## Requirements
- R1: After reset, all flags and all mask bits are 0 and `irq_n` is 1.
- R2: A pulse on `src_set[i]` makes flag bit i read as 1 from the cycle after the pulse. The bit positions are: CA2 = 0, CA1 = 1, shift = 2, CB2 = 3, CB1 = 4, timer 2 = 5, timer 1 = 6.
- R3: A write to the flag address (0xD) clears each flag bit whose written bit in 6:0 is 1. Every other flag keeps its value, and written bit 7 has no effect.
- R4: A pulse on `src_clr[i]` clears flag bit i from the next cycle.
- R5: If a set pulse for a bit arrives in the same cycle as a clear of that bit, from either source, the flag ends up set.
- R6: A write to the mask address (0xE) with bit 7 = 1 sets each mask bit whose written bit in 6:0 is 1. All other mask bits keep their value.
- R7: A write to the mask address with bit 7 = 0 clears each mask bit whose written bit in 6:0 is 1. All other mask bits keep their value.
- R8: A read of the mask address returns the mask in bits 6:0 and 1 in bit 7.
- R9: A read of the flag address returns the flags in bits 6:0. Bit 7 holds the live request: 1 when any bit of (flags AND mask) is 1. The read data is combinational from the current state.
- R10: `irq_n` is low in the cycle after the live request is 1, and high in the cycle after it is 0.
- R11: A write to any other address changes neither register, and a read of any other address returns 0.
- R12: A flag is recorded whether or not its mask bit is on. Turning the mask bit on later raises the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_set | input | 7 | Per-source set pulses |
| src_clr | input | 7 | Per-source clear pulses from other blocks |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| irq_n | output | 1 | Active-low registered interrupt request |

## Verification
Directed passes cover several cases, each separating one path from the others:
- Each source is pulsed alone while its mask bit is off. This separates flag capture from request generation.
- The mask is built up and torn down with both selector values. This separates set mode from clear mode.
- A set pulse lands in the same cycle as a software clear and as a hardware clear. This shows which side wins.
- Writes are made to unused addresses, to show they are ignored.

A long stream of sparse random set pulses, clear pulses and mixed writes then exercises overlapping events. It is compared each cycle against a reference model, with particular attention to the one-cycle lag between read bit 7 and `irq_n`.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int unsigned SRC_N      = 7;
  localparam int unsigned SRC_CA2    = 0;
  localparam int unsigned SRC_CA1    = 1;
  localparam int unsigned SRC_SHIFT  = 2;
  localparam int unsigned SRC_CB2    = 3;
  localparam int unsigned SRC_CB1    = 4;
  localparam int unsigned SRC_TMR2   = 5;
  localparam int unsigned SRC_TMR1   = 6;
  localparam int unsigned BYTE_W     = SRC_N + 1;

  typedef logic [SRC_N-1:0] src_vec_t;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_FLAG = 2'd1,
    SEL_MASK = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         sw_clr_en,
  input  logic [N-1:0] sw_clr_bits,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;
  logic [N-1:0] flag_nxt;
  logic [N-1:0] flag_ce;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic kill;
    always_comb begin
      kill        = clr_i[i] | (sw_clr_en & sw_clr_bits[i]);
      flag_ce[i]  = set_i[i] | kill;
      flag_nxt[i] = set_i[i] | (flag_q[i] & ~kill);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[i] <= 1'b0;
      else if (flag_ce[i]) flag_q[i] <= flag_nxt[i];
    end

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_q[i]);
    assert_flag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (kill && !set_i[i]) |=> !flag_q[i]);
    assert_flag_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i[i] && !kill) |=> $stable(flag_q[i]));
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic         mode_set_i,
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] mask_q;
  logic [N-1:0] mask_nxt;

  always_comb begin
    if (mode_set_i) mask_nxt = mask_q | bits_i;
    else            mask_nxt = mask_q & ~bits_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (wr_i) mask_q <= mask_nxt;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_mask_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && mode_set_i && bits_i[i]) |=> mask_q[i]);
    assert_mask_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !mode_set_i && bits_i[i]) |=> !mask_q[i]);
    assert_mask_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_i && bits_i[i]) |=> $stable(mask_q[i]));
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_line_drv.sv
module irq_line_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic irq_n_o
);
  logic irq_n_q;
  logic irq_ce;

  // update only when the driven level disagrees with the request
  always_comb irq_ce = (irq_n_q == req_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_n_q <= 1'b1;
    else if (irq_ce) irq_n_q <= ~req_i;
  end

  assert_irq_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> !irq_n_q);
  assert_irq_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> irq_n_q);

  assign irq_n_o = irq_n_q;
endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
  import irq_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 4'hD,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 4'hE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  src_set,
  input  logic [SRC_N-1:0]  src_clr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  output logic              irq_n
);
  localparam int unsigned SEL_BIT = BYTE_W - 1;

  logic     rst_s1;
  logic     rst_s2;
  reg_sel_e sel;
  src_vec_t flags;
  src_vec_t mask;
  logic     req;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  always_comb begin
    if (addr == FLAG_ADDR)      sel = SEL_FLAG;
    else if (addr == MASK_ADDR) sel = SEL_MASK;
    else                        sel = SEL_NONE;
  end

  irq_flag_bank #(.N(SRC_N)) u_flags (
    .clk         (clk),
    .rst_n       (rst_s2),
    .set_i       (src_set),
    .clr_i       (src_clr),
    .sw_clr_en   (wr_en && (sel == SEL_FLAG)),
    .sw_clr_bits (wr_data[SRC_N-1:0]),
    .flag_o      (flags)
  );

  irq_mask_bank #(.N(SRC_N)) u_mask (
    .clk        (clk),
    .rst_n      (rst_s2),
    .wr_i       (wr_en && (sel == SEL_MASK)),
    .mode_set_i (wr_data[SEL_BIT]),
    .bits_i     (wr_data[SRC_N-1:0]),
    .mask_o     (mask)
  );

  always_comb req = |(flags & mask);

  irq_line_drv u_line (
    .clk     (clk),
    .rst_n   (rst_s2),
    .req_i   (req),
    .irq_n_o (irq_n)
  );

  always_comb begin
    unique case (sel)
      SEL_FLAG: rd_data = {req, flags};
      SEL_MASK: rd_data = {1'b1, mask};
      default:  rd_data = '0;
    endcase
  end

  assert_stray_write_R11: assert property (@(posedge clk) disable iff (!rst_s2)
    (wr_en && sel == SEL_NONE && src_set == '0 && src_clr == '0)
      |=> ($stable(flags) && $stable(mask)));
  assert_masked_capture_R12: assert property (@(posedge clk) disable iff (!rst_s2)
    (src_set != '0) |=> ((flags & $past(src_set)) == $past(src_set)));
endmodule

// File: tb/irq_mask_unit_test.sv
`timescale 1ns/1ps
module irq_mask_unit_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] src_set, src_clr;
  logic       wr_en;
  logic [3:0] addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       irq_n;

  int vectors = 0;
  int misses  = 0;
  logic [6:0] fm = '0;
  logic [6:0] em = '0;
  logic       im = 1'b1;

  always #4 clk = ~clk;

  irq_mask_unit uut (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [3:0] a);
    if (a == 4'hD)      return {|(fm & em), fm};
    else if (a == 4'hE) return {1'b1, em};
    else                return 8'h00;
  endfunction

  // called at a negedge; drives, checks read, clocks, checks irq_n
  task automatic step(input logic [6:0] s, input logic [6:0] c, input logic we,
                      input logic [3:0] a, input logic [7:0] d, input string tag);
    src_set = s; src_clr = c; wr_en = we; addr = a; wr_data = d;
    #1;
    check8(tag, rd_data, model_read(a));
    @(posedge clk);
    im = ~|(fm & em);
    fm = (fm & ~c & ~((we && a == 4'hD) ? d[6:0] : 7'h00)) | s;
    if (we && a == 4'hE) em = d[7] ? (em | d[6:0]) : (em & ~d[6:0]);
    @(negedge clk);
    check8({tag, "/irq"}, {7'h0, irq_n}, {7'h0, im});
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    step(7'h0, 7'h0, 1'b0, a, 8'h00, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_set = '0; src_clr = '0; wr_en = 1'b0; addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(4'hD, "R1"); rd(4'hE, "R1");
    check8("R1", {7'h0, irq_n}, 8'h01);

    // R2 / R12 each source alone, masked off
    for (int i = 0; i < 7; i++) begin
      step(7'h1 << i, 7'h0, 1'b0, 4'hD, 8'h00, "R2");
      rd(4'hD, "R12");
    end
    // R6 / R8 / R9 / R10 enable a few
    step(7'h0, 7'h0, 1'b1, 4'hE, 8'hA0, "R6");
    rd(4'hE, "R8");
    rd(4'hD, "R9");
    rd(4'hD, "R10");
    // R3 software clear, bit 7 written as 1
    step(7'h0, 7'h0, 1'b1, 4'hD, 8'hA1, "R3");
    rd(4'hD, "R3");
    // R4 hardware clear
    step(7'h0, 7'h06, 1'b0, 4'hD, 8'h00, "R4");
    rd(4'hD, "R4");
    // R5 set vs clear in same cycle
    step(7'h08, 7'h08, 1'b1, 4'hD, 8'h08, "R5");
    rd(4'hD, "R5");
    // R7 clear-mode mask write
    step(7'h0, 7'h0, 1'b1, 4'hE, 8'h20, "R7");
    rd(4'hE, "R7");
    rd(4'hD, "R10");
    // R11 stray addresses
    step(7'h0, 7'h0, 1'b1, 4'h3, 8'hFF, "R11");
    step(7'h0, 7'h0, 1'b1, 4'hF, 8'h7F, "R11");
    rd(4'hD, "R11"); rd(4'hE, "R11"); rd(4'h0, "R11");
    // R12 later unmask raises request
    step(7'h0, 7'h0, 1'b1, 4'hE, 8'hFF, "R12");
    rd(4'hD, "R12");

    // mixed random stream, all requirements
    for (int n = 0; n < 400; n++) begin
      logic [6:0] s, c;
      logic [3:0] a;
      s = 7'($urandom & $urandom & $urandom);
      c = 7'($urandom & $urandom & $urandom);
      a = ($urandom % 3 == 0) ? 4'($urandom) : (($urandom % 2) ? 4'hD : 4'hE);
      step(s, c, 1'($urandom % 3 == 0), a, 8'($urandom), "R9");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule